// File: doc/BRIEF.md
# Dual-Port Address-Contention Arbiter

This block sits beside a true dual-port memory of 1024 locations by 8 bits and decides, once per clock, whether the left port and the right port are competing for the same location. Each port brings an active-low chip enable, an active-low write strobe and a 10-bit address. When both ports are enabled on one address, one of them keeps its access and the other sees its active-low busy output driven low. The losing port's write never reaches the array.

The port whose request was already present and unchanged in the previous cycle wins over a port that has just arrived. When both arrive in the same cycle, the left port wins. Once chosen, the winner is held for as long as the two requests keep matching, so a long collision cannot swap sides halfway through. Busy outputs are registered and follow the contention by one cycle. The qualified write enables toward the array are combinational, so a loser's write is blocked from the very first colliding cycle.

Top module: `dpa_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after it, both busy outputs are 1. While rst_n is low, both qualified write enables are 0.
- R2: If either chip enable is 1 or the two addresses differ in a cycle, both busy outputs are 1 after the next rising edge.
- R3: Contention exists in a cycle exactly when both chip enables are 0 and both addresses are equal. After that cycle's rising edge, the losing port's busy output is 0 and the winner's is 1.
- R4: At the first cycle of a contention, a port is stable if in the previous cycle it was enabled on the same address. If only one port is stable, that port wins.
- R5: At the first cycle of a contention, if neither port is stable, the left port wins.
- R6: While contention continues from one cycle to the next, the winner does not change.
- R7: The two busy outputs are never 0 together.
- R8: In every contention cycle, including the first, the losing port's qualified write enable is 0, whatever its write strobe.
- R9: After a cycle without contention, both busy outputs are 1.
- R10: Outside reset and for a port that is not losing, the qualified write enable is 1 exactly when that port's chip enable and write strobe are both 0 in the same cycle; a read (strobe 1) never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| left_en_n | input | 1 | Left chip enable, active low |
| left_wr_n | input | 1 | Left write strobe, active low |
| left_addr | input | 10 | Left location address |
| right_en_n | input | 1 | Right chip enable, active low |
| right_wr_n | input | 1 | Right write strobe, active low |
| right_addr | input | 10 | Right location address |
| left_busy_n | output | 1 | Left busy, active low, registered |
| right_busy_n | output | 1 | Right busy, active low, registered |
| left_mem_we | output | 1 | Qualified left write enable to the array, active high |
| right_mem_we | output | 1 | Qualified right write enable to the array, active high |

## Verification
The properties assume that port inputs are stable for a whole clock period and change only between edges. They also assume that "arrival" is judged at cycle granularity, so two ports that change in the same period count as simultaneous. The stimulus drives every input on the falling edge. It draws addresses from a four-location window so that collisions, held collisions and mid-collision departures occur often. Directed sequences then force same-cycle arrival, a late arrival against a settled port, and release by deselection.

// File: rtl/dpa_pkg.sv
// Shared types for the dual-port contention arbiter.
// Assumes: only two ports exist, encoded as a single-bit side.
package dpa_pkg;
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dpa_port_track.sv
// Per-port request history. Remembers whether the port was enabled and on
// which address in the previous cycle. It reports the port as "stable" when
// the current request repeats that one.
// Assumes: inputs are settled before each rising edge.
module dpa_port_track #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              req,
    output logic              stable
);
    logic              prev_req;
    logic [ADDR_W-1:0] prev_addr;

    // Active request is simply an asserted chip enable.
    always_comb req = ~en_n;

    // Stable means the identical request was already present last cycle.
    always_comb stable = req & prev_req & (prev_addr == addr);

    // Capture this cycle's request for the next comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_req  <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_req  <= req;
            prev_addr <= addr;
        end
    end
endmodule

// File: rtl/dpa_winner.sv
// Contention winner selection. On a fresh contention the settled port wins,
// and the left port wins a tie. The choice is held for as long as
// contention continues.
// Assumes: match is asserted only when both ports request one address.
module dpa_winner
    import dpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic stable_l,
    input  logic stable_r,
    output logic lose_l,
    output logic lose_r
);
    logic  prev_match;
    side_e win_q;
    side_e win_d;

    // Pick the winner: hold during continuing contention, else earlier arrival.
    always_comb begin
        if (match && prev_match) begin
            win_d = win_q;
        end else if (stable_r && !stable_l) begin
            win_d = SIDE_RIGHT;
        end else begin
            win_d = SIDE_LEFT;
        end
    end

    // The loser is the side opposite the winner, only while matching.
    always_comb begin
        lose_l = match && (win_d == SIDE_RIGHT);
        lose_r = match && (win_d == SIDE_LEFT);
    end

    // Remember the contention state and the winner for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_match <= 1'b0;
            win_q      <= SIDE_LEFT;
        end else begin
            prev_match <= match;
            win_q      <= match ? win_d : SIDE_LEFT;
        end
    end
endmodule

// File: rtl/dpa_busy_gate.sv
// Output stage for both sides. It registers the active-low busy flags and
// gates each side's write strobe into a qualified array write enable.
// Assumes: lose flags are mutually exclusive and valid in the same cycle.
module dpa_busy_gate
    import dpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SIDES-1:0] req,
    input  logic [NUM_SIDES-1:0] wr_n,
    input  logic [NUM_SIDES-1:0] lose,
    output logic [NUM_SIDES-1:0] busy_n,
    output logic [NUM_SIDES-1:0] mem_we
);
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        // Qualified write: enabled, strobing, not losing, not in reset.
        always_comb mem_we[s] = rst_n & req[s] & ~wr_n[s] & ~lose[s];

        // Busy follows this cycle's loss, one edge later; inactive in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_n[s] <= 1'b1;
            end else begin
                busy_n[s] <= ~lose[s];
            end
        end
    end
endmodule

// File: rtl/dpa_arbiter.sv
// Top of the dual-port address-contention arbiter. It tracks each port's
// request history, detects an enabled address match, selects a winner,
// drives registered busy flags and gates the loser's write.
// Assumes: synchronous ports sharing clk; inputs change between edges.
module dpa_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_en_n,
    input  logic              left_wr_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              right_en_n,
    input  logic              right_wr_n,
    input  logic [ADDR_W-1:0] right_addr,
    output logic              left_busy_n,
    output logic              right_busy_n,
    output logic              left_mem_we,
    output logic              right_mem_we
);
    localparam int LEFT_IDX  = int'(SIDE_LEFT);
    localparam int RIGHT_IDX = int'(SIDE_RIGHT);

    logic [NUM_SIDES-1:0]             en_n_v;
    logic [NUM_SIDES-1:0]             wr_n_v;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_SIDES-1:0]             req_v;
    logic [NUM_SIDES-1:0]             stable_v;
    logic [NUM_SIDES-1:0]             lose_v;
    logic [NUM_SIDES-1:0]             busy_v;
    logic [NUM_SIDES-1:0]             we_v;
    logic                             match;

    // Gather both ports into side-indexed vectors.
    always_comb begin
        en_n_v[LEFT_IDX]  = left_en_n;
        en_n_v[RIGHT_IDX] = right_en_n;
        wr_n_v[LEFT_IDX]  = left_wr_n;
        wr_n_v[RIGHT_IDX] = right_wr_n;
        addr_v[LEFT_IDX]  = left_addr;
        addr_v[RIGHT_IDX] = right_addr;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_track
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_n   (en_n_v[s]),
            .addr   (addr_v[s]),
            .req    (req_v[s]),
            .stable (stable_v[s])
        );
    end

    // Contention: both ports selected on the same location.
    always_comb match = req_v[LEFT_IDX] & req_v[RIGHT_IDX]
                      & (addr_v[LEFT_IDX] == addr_v[RIGHT_IDX]);

    dpa_winner u_winner (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .stable_l (stable_v[LEFT_IDX]),
        .stable_r (stable_v[RIGHT_IDX]),
        .lose_l   (lose_v[LEFT_IDX]),
        .lose_r   (lose_v[RIGHT_IDX])
    );

    dpa_busy_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_v),
        .wr_n   (wr_n_v),
        .lose   (lose_v),
        .busy_n (busy_v),
        .mem_we (we_v)
    );

    // Drive the ports from the side-indexed results.
    always_comb begin
        left_busy_n  = busy_v[LEFT_IDX];
        right_busy_n = busy_v[RIGHT_IDX];
        left_mem_we  = we_v[LEFT_IDX];
        right_mem_we = we_v[RIGHT_IDX];
    end
endmodule

// File: rtl/dpa_arbiter_chk.sv
// Property checker for dpa_arbiter, attached by bind. It observes ports only.
module dpa_arbiter_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              left_en_n,
    input logic              left_wr_n,
    input logic [ADDR_W-1:0] left_addr,
    input logic              right_en_n,
    input logic              right_wr_n,
    input logic [ADDR_W-1:0] right_addr,
    input logic              left_busy_n,
    input logic              right_busy_n,
    input logic              left_mem_we,
    input logic              right_mem_we
);
    logic collide;
    // Port-level contention condition, observed for the properties.
    always_comb collide = !left_en_n && !right_en_n && (left_addr == right_addr);

    a_r7_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!left_busy_n && !right_busy_n));

    a_r8_no_shared_write: assert property (@(posedge clk) disable iff (!rst_n)
        (left_mem_we && right_mem_we) |-> (left_addr != right_addr));

    a_r3_left_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !left_busy_n |-> $past(collide));

    a_r3_right_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !right_busy_n |-> $past(collide));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !collide |=> (left_busy_n && right_busy_n));

    a_r6_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !left_busy_n |-> $past(right_busy_n));

    a_r10_left_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        left_mem_we |-> (!left_en_n && !left_wr_n));

    a_r10_right_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        right_mem_we |-> (!right_en_n && !right_wr_n));
endmodule

bind dpa_arbiter dpa_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .left_en_n    (left_en_n),
    .left_wr_n    (left_wr_n),
    .left_addr    (left_addr),
    .right_en_n   (right_en_n),
    .right_wr_n   (right_wr_n),
    .right_addr   (right_addr),
    .left_busy_n  (left_busy_n),
    .right_busy_n (right_busy_n),
    .left_mem_we  (left_mem_we),
    .right_mem_we (right_mem_we)
);

// File: tb/test_dpa_arbiter.sv
`timescale 1ns/1ps
module test_dpa_arbiter;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          left_en_n = 1'b1, left_wr_n = 1'b1;
    logic          right_en_n = 1'b1, right_wr_n = 1'b1;
    logic [AW-1:0] left_addr = '0, right_addr = '0;
    logic          left_busy_n, right_busy_n, left_mem_we, right_mem_we;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Bench reference state, built from the requirements.
    logic          m_pmatch = 0, m_pwin = 0;
    logic          m_plreq = 0, m_prreq = 0;
    logic [AW-1:0] m_pladdr = '0, m_praddr = '0;
    logic          exp_bl = 1, exp_br = 1;
    string         last_tag = "R1";

    always #2.5 clk = ~clk;

    dpa_arbiter #(.ADDR_W(AW)) i_dpa_arbiter (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Winner by the requirements: hold (R6), settled port (R4), else left (R5).
    function automatic logic ref_win(input logic match, input logic sl, input logic sr);
        if (match && m_pmatch) return m_pwin;
        if (sr && !sl) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input logic le, input logic lw, input logic [AW-1:0] la,
                        input logic re, input logic rw, input logic [AW-1:0] ra,
                        input string tag);
        logic m, sl, sr, w, ll, lr, ewl, ewr;
        @(negedge clk);
        check(left_busy_n === exp_bl && right_busy_n === exp_br, last_tag, "busy",
              {left_busy_n, right_busy_n}, {exp_bl, exp_br});
        check(!(!left_busy_n && !right_busy_n), "R7", "busy both low",
              {left_busy_n, right_busy_n}, 2'b11);
        left_en_n = le; left_wr_n = lw; left_addr = la;
        right_en_n = re; right_wr_n = rw; right_addr = ra;
        #1;
        m  = !le && !re && (la == ra);
        sl = !le && m_plreq && (m_pladdr == la);
        sr = !re && m_prreq && (m_praddr == ra);
        w  = ref_win(m, sl, sr);
        ll = m && w;
        lr = m && !w;
        ewl = !le && !lw && !ll;
        ewr = !re && !rw && !lr;
        check(left_mem_we === ewl && right_mem_we === ewr, tag, "write enable",
              {left_mem_we, right_mem_we}, {ewl, ewr});
        @(posedge clk);
        exp_bl = !ll; exp_br = !lr;
        m_pmatch = m; m_pwin = m ? w : 1'b0;
        m_plreq = !le; m_pladdr = la; m_prreq = !re; m_praddr = ra;
        last_tag = tag;
    endtask

    initial begin
        void'($urandom(32'd2718));
        // R1: reset state with write requests present
        left_en_n = 0; left_wr_n = 0; right_en_n = 0; right_wr_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(left_busy_n === 1 && right_busy_n === 1, "R1", "busy in reset",
              {left_busy_n, right_busy_n}, 2'b11);
        check(left_mem_we === 0 && right_mem_we === 0, "R1", "we in reset",
              {left_mem_we, right_mem_we}, 2'b00);
        left_en_n = 1; right_en_n = 1;
        @(negedge clk);
        rst_n = 1;
        // R2/R10: different addresses, both writing
        step(0, 0, 10'h010, 0, 0, 10'h011, "R2");
        // R10: reads do not raise write enables
        step(0, 1, 10'h020, 0, 1, 10'h021, "R10");
        // R5/R8: same-cycle arrival on one address, right write blocked
        step(1, 1, 10'h000, 1, 1, 10'h000, "R2");
        step(0, 0, 10'h3FF, 0, 0, 10'h3FF, "R5");
        // R6: collision held, left writes, right still losing
        step(0, 0, 10'h3FF, 0, 0, 10'h3FF, "R6");
        step(0, 1, 10'h3FF, 0, 0, 10'h3FF, "R6");
        // R9: left deselects, release
        step(1, 1, 10'h3FF, 0, 0, 10'h3FF, "R9");
        // R4/R8: right settled, left arrives and its write is blocked
        step(0, 0, 10'h3FF, 0, 1, 10'h3FF, "R4");
        step(0, 0, 10'h3FF, 0, 1, 10'h3FF, "R3");
        // R9: addresses diverge
        step(0, 0, 10'h005, 0, 0, 10'h3FF, "R9");
        step(1, 1, 10'h000, 1, 1, 10'h000, "R2");
        // Random mix: small address window forces frequent contention
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) < 3, $urandom % 2, 10'($urandom % 4),
                 ($urandom % 10) < 3, $urandom % 2, 10'($urandom % 4),
                 "R3 R4 R6 R8 random");
        end
        step(1, 1, 10'h000, 1, 1, 10'h000, "R9");
        @(negedge clk);
        check(left_busy_n === exp_bl && right_busy_n === exp_br, last_tag, "busy",
              {left_busy_n, right_busy_n}, {exp_bl, exp_br});
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%b expected=%b", 1'b0, 1'b1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule